// File: doc/BRIEF.md
# Quadlet-to-Narrow-Port Byte Serializer

This block takes one 32-bit quadlet at a time, together with a count of valid bytes (1 to 4), and sends it out on a narrow data port one beat per cycle. A configuration input chooses the byte ordering, little-endian or big-endian. A mode input chooses the port width, 8 or 16 bits. In byte-wide mode only the valid bytes are sent. In halfword mode the quadlet always takes two beats, and the unused byte positions go out as zero.

Both sides use valid/ready handshakes, and the output flags the final beat of each quadlet. The ordering and width choices are captured together with the quadlet, so changing them while a quadlet is being sent has no effect on it. A new quadlet is taken in the same cycle as the previous one's last beat, so a stream of quadlets flows without idle cycles. A count of zero is handled as a full quadlet and produces a one-cycle error pulse.

Top module: `qser_top`

## Requirements
- R1: Byte Dk of the quadlet is `in_data[8k+7:8k]` (D0 in bits 7:0). A byte-wide beat uses `out_data[7:0]` with `out_data[15:8]` at zero. A halfword beat written {Da,Db} has Da in `out_data[15:8]` and Db in `out_data[7:0]`. A count of N marks D0..D(N-1) valid, and the bytes above them count as 00h.
- R2: When `cfg_wide`=0 and `cfg_little`=0, a quadlet with count N produces exactly N beats: D0, D1, … D(N-1).
- R3: When `cfg_wide`=0 and `cfg_little`=1, a quadlet with count N produces exactly N beats: D(N-1) down to D0.
- R4: When `cfg_wide`=1 and `cfg_little`=0, every quadlet produces exactly two beats, {D0,D1} and then {D2,D3}, with invalid bytes sent as 00h.
- R5: When `cfg_wide`=1 and `cfg_little`=1, every quadlet produces exactly two beats, {D2,D3} and then {D0,D1}, with invalid bytes sent as 00h.
- R6: `out_last` is 1 on the final beat of each quadlet and 0 on every other beat.
- R7: A count of 0 is handled as a count of 4, and `err_count` is 1 for exactly the cycle after that quadlet is accepted. A count of 5 to 7 is also handled as 4, but without the error pulse.
- R8: `cfg_little` and `cfg_wide` are sampled when a quadlet is accepted. Changing them while that quadlet is being sent does not alter any of its beats.
- R9: `in_ready` is 1 whenever no quadlet is held, and also while the last held beat is being taken. A stream of quadlets under constant `out_ready` therefore leaves no idle output cycle between them.
- R10: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_data` and `out_last` hold their values into the next cycle.
- R11: A synchronous active-high `rst` makes `out_valid` 0 and `err_count` 0 after the clock edge. It drops any quadlet that is partly sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A quadlet is offered |
| in_ready | output | 1 | The block takes the offered quadlet at this edge |
| in_data | input | 32 | Quadlet bytes D3..D0, with D0 in the low byte |
| in_count | input | 3 | Number of valid bytes, 1 to 4 |
| cfg_little | input | 1 | 1 selects little-endian ordering, 0 selects big-endian |
| cfg_wide | input | 1 | 1 selects the 16-bit port, 0 the 8-bit port |
| out_valid | output | 1 | A beat is presented |
| out_ready | input | 1 | The sink takes the beat at this edge |
| out_data | output | 16 | Beat data |
| out_last | output | 1 | Final beat of the quadlet |
| err_count | output | 1 | One-cycle pulse after a quadlet with count 0 is accepted |

## Verification
The first beat of a quadlet is on the port in the cycle right after the edge that accepts it. Each later beat follows one cycle after the edge where the one before it was taken, and `err_count` is valid during the cycle after acceptance only. The bench drives inputs and samples outputs one time unit after the falling edge. At that point every value registered at the preceding rising edge is settled, and the handshake that the next rising edge will complete is already known. The monitor compares a beat only in a cycle where `out_valid` and `out_ready` are both high. In the cycle after a stall it checks that the beat is unchanged, and it counts runs of beats, which catches a bubble between quadlets sent back to back.

// File: rtl/qser_pkg.sv
package qser_pkg;
    localparam int BYTE_W = 8;
    localparam int LANES  = 4;
    localparam int OUT_W  = 2 * BYTE_W;
    localparam int CNT_W  = $clog2(LANES) + 1;
    localparam int IDX_W  = $clog2(LANES);
    localparam int HALVES = LANES / 2;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef byte_t [LANES-1:0] quad_t;

    typedef struct packed {
        logic [LANES-1:0][OUT_W-1:0] beat;
        logic [IDX_W-1:0]            last_idx;
    } plan_t;
endpackage

// File: rtl/qser_pad.sv
module qser_pad
    import qser_pkg::*;
(
    input  quad_t            raw,
    input  logic [CNT_W-1:0] count,
    output quad_t            padded,
    output logic [CNT_W-1:0] eff_cnt,
    output logic             zero_cnt
);
    always_comb begin
        zero_cnt = (count == '0);
        if (zero_cnt || count > CNT_W'(LANES)) eff_cnt = CNT_W'(LANES);
        else                                   eff_cnt = count;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign padded[g] = (CNT_W'(g) < eff_cnt) ? raw[g] : '0;
    end
endmodule

// File: rtl/qser_order.sv
module qser_order
    import qser_pkg::*;
(
    input  quad_t            padded,
    input  logic [CNT_W-1:0] eff_cnt,
    input  logic             little,
    input  logic             wide,
    output plan_t            plan
);
    logic [IDX_W-1:0] src;

    always_comb begin
        plan = '0;
        src  = '0;
        if (wide) begin
            for (int h = 0; h < HALVES; h++) begin
                src = little ? IDX_W'(HALVES - 1 - h) : IDX_W'(h);
                plan.beat[h] = {padded[2*src], padded[2*src+1]};
            end
            plan.last_idx = IDX_W'(HALVES - 1);
        end else begin
            for (int i = 0; i < LANES; i++) begin
                if (CNT_W'(i) < eff_cnt) begin
                    src = little ? IDX_W'(eff_cnt - CNT_W'(1) - CNT_W'(i)) : IDX_W'(i);
                    plan.beat[i] = {{BYTE_W{1'b0}}, padded[src]};
                end
            end
            plan.last_idx = IDX_W'(eff_cnt - CNT_W'(1));
        end
    end
endmodule

// File: rtl/qser_engine.sv
module qser_engine
    import qser_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  plan_t            plan_in,
    input  logic             zero_in,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [OUT_W-1:0] out_data,
    output logic             out_last,
    output logic             err
);
    typedef struct packed {
        logic             busy;
        plan_t            plan;
        logic [IDX_W-1:0] idx;
        logic             err;
    } state_t;

    state_t st_q, st_d;
    logic   at_last, fire, accept;

    always_comb begin
        at_last  = (st_q.idx == st_q.plan.last_idx);
        fire     = st_q.busy && out_ready;
        in_ready = !st_q.busy || (out_ready && at_last);
        accept   = in_valid && in_ready;

        st_d     = st_q;
        st_d.err = 1'b0;
        if (fire) begin
            if (at_last) st_d.busy = 1'b0;
            else         st_d.idx  = st_q.idx + IDX_W'(1);
        end
        if (accept) begin
            st_d.busy = 1'b1;
            st_d.plan = plan_in;
            st_d.idx  = '0;
            st_d.err  = zero_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid = st_q.busy;
    assign out_data  = st_q.plan.beat[st_q.idx];
    assign out_last  = st_q.busy && at_last;
    assign err       = st_q.err;

    // R10: a stalled beat is held
    a_r10_hold_stalled: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

    // R9: an idle engine always offers to take a quadlet
    a_r9_ready_when_idle: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> in_ready);

    // R6: a taken last beat with nothing offered leaves the port empty
    a_r6_last_ends: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && out_last && !in_valid |=> !out_valid);

    // R11: reset clears the output
    a_r11_reset_clears: assert property (@(posedge clk)
        rst |=> !out_valid && !err);
endmodule

// File: rtl/qser_top.sv
module qser_top
    import qser_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [LANES*BYTE_W-1:0]   in_data,
    input  logic [CNT_W-1:0]          in_count,
    input  logic                      cfg_little,
    input  logic                      cfg_wide,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [OUT_W-1:0]          out_data,
    output logic                      out_last,
    output logic                      err_count
);
    quad_t            padded;
    logic [CNT_W-1:0] eff_cnt;
    logic             zero_cnt;
    plan_t            plan;

    qser_pad u_pad (
        .raw      (quad_t'(in_data)),
        .count    (in_count),
        .padded   (padded),
        .eff_cnt  (eff_cnt),
        .zero_cnt (zero_cnt)
    );

    qser_order u_order (
        .padded  (padded),
        .eff_cnt (eff_cnt),
        .little  (cfg_little),
        .wide    (cfg_wide),
        .plan    (plan)
    );

    qser_engine u_engine (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .plan_in   (plan),
        .zero_in   (zero_cnt),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_last  (out_last),
        .err       (err_count)
    );

    // R7: the error pulse always follows an accepted zero count
    a_r7_err_cause: assert property (@(posedge clk) disable iff (rst)
        err_count |-> $past(in_valid && in_ready && in_count == '0));

    // R1: a byte-wide beat leaves the upper byte at zero
    a_r1_narrow_upper_zero: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && !cfg_wide |=> out_data[OUT_W-1:BYTE_W] == '0);
endmodule

// File: tb/test_qser_top.sv
module test_qser_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic [2:0]  in_count = '0;
    logic        cfg_little = 1'b0;
    logic        cfg_wide = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [15:0] out_data;
    logic        out_last;
    logic        err_count;

    qser_top i_qser_top (.*);

    always #2 clk = ~clk;

    typedef struct {
        logic [15:0] data;
        logic        last;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    int   rdy_mode = 0;
    int   cyc = 0;
    int   last_fire = -10;
    int   runs = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic        was_stall = 1'b0;
    logic [15:0] stall_data;
    logic        stall_last;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    always @(negedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (rdy_mode)
            0:       out_ready = 1'b1;
            1:       out_ready = lfsr[0] | lfsr[3];
            default: out_ready = 1'b0;
        endcase
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        #1;
        cyc++;
        if (!rst) begin
            if (was_stall) begin
                chk(out_valid === 1'b1 && out_data === stall_data && out_last === stall_last,
                    "R10 hold", {15'd0, out_last, out_data}, {15'd0, stall_last, stall_data});
            end
            was_stall = out_valid && !out_ready;
            stall_data = out_data;
            stall_last = out_last;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected beat", {16'd0, out_data}, 32'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(out_data === e.data, e.req, {16'd0, out_data}, {16'd0, e.data});
                    chk(out_last === e.last, "R6 last flag", {31'd0, out_last}, {31'd0, e.last});
                end
                if (cyc != last_fire + 1) runs++;
                last_fire = cyc;
            end
        end else begin
            was_stall = 1'b0;
        end
    end

    task automatic expect_q(input logic [31:0] d, input int cnt, input bit little, input bit wide);
        logic [7:0] b[4];
        logic [7:0] p[4];
        int n;
        exp_t e;
        for (int k = 0; k < 4; k++) b[k] = d[8*k +: 8];
        n = (cnt == 0 || cnt > 4) ? 4 : cnt;
        for (int k = 0; k < 4; k++) p[k] = (k < n) ? b[k] : 8'h00;
        if (!wide) begin
            for (int i = 0; i < n; i++) begin
                e.data = {8'h00, little ? b[n-1-i] : b[i]};
                e.last = (i == n - 1);
                e.req  = little ? "R3 narrow little" : "R2 narrow big";
                exp_q.push_back(e);
            end
        end else begin
            e.req  = little ? "R5 wide little" : "R4 wide big";
            e.data = little ? {p[2], p[3]} : {p[0], p[1]};
            e.last = 1'b0;
            exp_q.push_back(e);
            e.data = little ? {p[0], p[1]} : {p[2], p[3]};
            e.last = 1'b1;
            exp_q.push_back(e);
        end
    endtask

    // called one time unit after a falling edge; returns at the same phase
    task automatic send(input logic [31:0] d, input int cnt, input bit little, input bit wide);
        expect_q(d, cnt, little, wide);
        in_data    = d;
        in_count   = 3'(cnt);
        cfg_little = little;
        cfg_wide   = wide;
        in_valid   = 1'b1;
        while (in_ready !== 1'b1) begin
            @(negedge clk); #1;
        end
        @(negedge clk); #1;
        chk(err_count === (cnt == 0), "R7 error pulse", {31'd0, err_count}, {31'd0, cnt == 0});
        in_valid   = 1'b0;
        // R8: flip the configuration while the quadlet is in flight
        cfg_little = ~little;
        cfg_wide   = ~wide;
    endtask

    task automatic drain();
        int guard = 0;
        while (exp_q.size() != 0 && guard < 1000) begin
            @(negedge clk); #1;
            guard++;
        end
        @(negedge clk); #1;
    endtask

    initial begin
        int r0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(out_valid === 1'b0, "R11 reset valid", {31'd0, out_valid}, 32'd0);
        chk(in_ready === 1'b1, "R9 ready idle", {31'd0, in_ready}, 32'd1);
        chk(err_count === 1'b0, "R11 reset err", {31'd0, err_count}, 32'd0);

        // all modes and counts, free-running sink
        for (int w = 0; w < 2; w++)
            for (int l = 0; l < 2; l++)
                for (int c = 1; c <= 4; c++)
                    send(32'h44332211 + 32'(c * 16'h0101 + l * 32'h10000000), c, l[0], w[0]);
        drain();

        // zero and oversize counts (R7)
        send(32'hDDCCBBAA, 0, 1'b0, 1'b0);
        send(32'h0F0E0D0C, 0, 1'b1, 1'b1);
        send(32'h87654321, 5, 1'b1, 1'b0);
        drain();

        // back-to-back stream: one run of beats (R9)
        r0 = runs;
        send(32'hA3A2A1A0, 4, 1'b0, 1'b0);
        send(32'hB3B2B1B0, 4, 1'b1, 1'b0);
        send(32'hC3C2C1C0, 3, 1'b0, 1'b1);
        send(32'hD3D2D1D0, 2, 1'b1, 1'b1);
        drain();
        chk(runs - r0 == 1, "R9 no bubble", 32'(runs - r0), 32'd1);

        // stalling sink (R10, R8)
        rdy_mode = 1;
        for (int i = 0; i < 24; i++)
            send(32'h13579BDF ^ 32'(i * 32'h01020408), (i % 5), i[0], i[1]);
        drain();
        rdy_mode = 0;

        // reset mid-quadlet (R11)
        rdy_mode = 2;
        @(negedge clk); #1;
        send(32'h55667788, 4, 1'b0, 1'b0);
        @(negedge clk); #1;
        rst = 1'b1;
        @(negedge clk); #1;
        chk(out_valid === 1'b0, "R11 mid reset", {31'd0, out_valid}, 32'd0);
        exp_q.delete();
        rst = 1'b0;
        rdy_mode = 0;
        repeat (5) @(negedge clk);
        #1;
        chk(out_valid === 1'b0, "R11 discarded", {31'd0, out_valid}, 32'd0);
        send(32'h0000C0DE, 2, 1'b1, 1'b0);
        drain();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule